// File: doc/BRIEF.md
# SD Command Launcher with Response Capture

This block sits between a host register interface and a card-side model of an SD card. Software first loads a 32-bit argument, then writes a 16-bit command word. If that word carries the launch bit, the block presents the command index and a frozen copy of the argument to the card and holds its request valid. The card answers with a stream of response bytes. It closes the exchange with an end strobe that carries the byte count and a failure flag.

At the end strobe the block checks the length against the response kind that the command word asked for. A good answer is packed into four 32-bit response words, most significant byte first. A long answer is stored with the word order reversed. A bad length or a card failure instead sets a fail flag in the command word and a sticky command-timeout status bit. The launch bit then clears, and a one-cycle done pulse tells a downstream data path that it may start.

Top module: `sd_cmd_issue`

## Requirements
- R1: After reset, the command word, the argument, all four response words and the status word read as zero, and both `cardReqValid` and `cmdDone` are low.
- R2: A write to offset 0x04 stores all 32 bits of the argument and reads back unchanged. A write to offset 0x00 with bit 15 clear stores the low 16 bits as the command word and raises no request.
- R3: A write to offset 0x00 with bit 15 set raises `cardReqValid` from the next cycle. While the request waits, `cardReqIndex` equals command bits 5:0, `cardReqArg` equals the argument held at launch, and command bit 15 reads as 1.
- R4: A `rspEnd` seen while a request waits ends it. In the next cycle `cardReqValid` is low, command bit 15 reads 0, and `cmdDone` is high for exactly that one cycle, with the results already readable.
- R5: When a response is expected (command bit 10 clear) and the long bit 9 is clear, a length of 4 fills response word 0 at offset 0x10 with the first received byte in bits 31:24. Response words 1 to 3 (0x14, 0x18, 0x1C) become zero.
- R6: When a response is expected, a length of 16 fills word 3 (0x1C) from bytes 0-3, word 2 from bytes 4-7, word 1 from bytes 8-11 and word 0 from bytes 12-15. Each word takes its earliest byte in bits 31:24.
- R7: When a response is expected, a length of 0, a length of 4 with bit 9 set, or any length other than 4 or 16 sets command bit 14 and status bit 6, and leaves the response words unchanged.
- R8: A `rspFail` at the end strobe sets command bit 14 and status bit 6 and leaves the response words unchanged, whatever the length.
- R9: With command bit 10 set, the length is not checked and the response words stay unchanged. Bit 14 is set only by `rspFail`.
- R10: While a request waits, writes to the command word are ignored. Argument writes update the argument register but leave `cardReqArg` unchanged.
- R11: Status bit 6 (offset 0x20) stays set until software writes 1 to bit 6 of that offset. Writing 0 there leaves it set. All other status bits read 0.
- R12: `rspByteValid` and `rspEnd` while no request waits have no effect. No done pulse follows, and the response words stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W (8) | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| cardReqValid | output | 1 | Request pending towards the card |
| cardReqIndex | output | 6 | Command index presented to the card |
| cardReqArg | output | 32 | Argument presented to the card |
| rspByteValid | input | 1 | Response byte strobe |
| rspByte | input | 8 | Response byte, earliest first |
| rspEnd | input | 1 | End of response |
| rspLen | input | LEN_W (5) | Response byte count, valid with `rspEnd` |
| rspFail | input | 1 | Card reports a failed request, valid with `rspEnd` |
| cmdDone | output | 1 | One-cycle completion pulse |

## Verification
The properties assume the card only strobes bytes and the end marker in the exchange it was asked for. They also assume the byte count it reports matches the bytes it actually sent when a response is valid. The stimulus always sends exactly `rspLen` bytes before the end strobe, and drives stray traffic only in one directed idle case whose effect the bench checks at the ports. Randomized commands mix every length class, the long and no-response bits, and occasional card failures. Writes to the command and argument registers during a pending request are confined to a directed case.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  localparam int WORD_W      = 32;
  localparam int CMD_W       = 16;
  localparam int IDX_W       = 6;
  localparam int RSP_WORDS   = 4;
  localparam int RSP_BITS    = RSP_WORDS * WORD_W;
  localparam int SHORT_BYTES = WORD_W / 8;
  localparam int LONG_BYTES  = RSP_BITS / 8;

  localparam int BIT_NEW     = 15;
  localparam int BIT_FAIL    = 14;
  localparam int BIT_NORSP   = 10;
  localparam int BIT_LONG    = 9;
  localparam int STS_TIMEOUT = 6;

  localparam int OFF_CMD  = 'h00;
  localparam int OFF_ARG  = 'h04;
  localparam int OFF_RSP0 = 'h10;
  localparam int OFF_STS  = 'h20;

  typedef enum logic {ST_IDLE, ST_WAIT} cmdState_t;

  typedef struct packed {
    logic wrCmd;
    logic wrArg;
    logic clrSts;
    logic launch;
    logic shiftByte;
    logic fileShort;
    logic fileLong;
    logic markFail;
    logic finish;
  } cmdStrobe_t;
endpackage

// File: rtl/sd_cmd_ctrl.sv
module sd_cmd_ctrl
  import sd_cmd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrNewBit,
  input  logic              cmdNoRsp,
  input  logic              cmdLong,
  input  logic              rspByteValid,
  input  logic              rspEnd,
  input  logic [LEN_W-1:0]  rspLen,
  input  logic              rspFail,
  output cmdStrobe_t        stb,
  output logic              busy,
  output logic              donePulse
);
  cmdState_t state;
  logic hitCmd, lenShort, lenLong;

  assign lenShort = (rspLen == LEN_W'(SHORT_BYTES));
  assign lenLong  = (rspLen == LEN_W'(LONG_BYTES));
  assign busy     = (state == ST_WAIT);

  always_comb begin
    stb        = '0;
    hitCmd     = regWrEn && (regAddr == ADDR_W'(OFF_CMD));
    stb.wrArg  = regWrEn && (regAddr == ADDR_W'(OFF_ARG));
    stb.clrSts = regWrEn && (regAddr == ADDR_W'(OFF_STS));
    stb.wrCmd  = hitCmd && (state == ST_IDLE);
    stb.launch = stb.wrCmd && wrNewBit;
    if (state == ST_WAIT) begin
      stb.shiftByte = rspByteValid;
      if (rspEnd) begin
        stb.finish = 1'b1;
        if (rspFail) begin
          stb.markFail = 1'b1;
        end else if (!cmdNoRsp) begin
          if (lenShort && !cmdLong) stb.fileShort = 1'b1;
          else if (lenLong)         stb.fileLong  = 1'b1;
          else                      stb.markFail  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      donePulse <= 1'b0;
    end else begin
      donePulse <= stb.finish;
      case (state)
        ST_IDLE: if (stb.launch) state <= ST_WAIT;
        ST_WAIT: if (rspEnd)     state <= ST_IDLE;
        default:                 state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_cmd_dpath.sv
module sd_cmd_dpath
  import sd_cmd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  cmdStrobe_t          stb,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [WORD_W-1:0]   regWrData,
  input  logic [7:0]          rspByte,
  output logic [WORD_W-1:0]   regRdData,
  output logic [CMD_W-1:0]    cmdWord,
  output logic [WORD_W-1:0]   stsWord,
  output logic [RSP_BITS-1:0] rspFlat,
  output logic [WORD_W-1:0]   reqArg
);
  logic [WORD_W-1:0]   argReg;
  logic [RSP_BITS-1:0] shiftBuf, bufNext;
  logic                stsTimeout;

  assign bufNext = stb.shiftByte ? {shiftBuf[RSP_BITS-9:0], rspByte} : shiftBuf;
  assign stsWord = WORD_W'({stsTimeout, {STS_TIMEOUT{1'b0}}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdWord    <= '0;
      argReg     <= '0;
      reqArg     <= '0;
      shiftBuf   <= '0;
      rspFlat    <= '0;
      stsTimeout <= 1'b0;
    end else begin
      if (stb.wrCmd)    cmdWord <= regWrData[CMD_W-1:0];
      if (stb.finish)   cmdWord[BIT_NEW] <= 1'b0;
      if (stb.markFail) cmdWord[BIT_FAIL] <= 1'b1;
      if (stb.wrArg)    argReg <= regWrData;
      if (stb.launch)   reqArg <= argReg;
      if (stb.launch)         shiftBuf <= '0;
      else if (stb.shiftByte) shiftBuf <= bufNext;
      if (stb.fileLong)       rspFlat <= bufNext;
      else if (stb.fileShort) rspFlat <= RSP_BITS'(bufNext[WORD_W-1:0]);
      if (stb.markFail) stsTimeout <= 1'b1;
      else if (stb.clrSts && regWrData[STS_TIMEOUT]) stsTimeout <= 1'b0;
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(OFF_CMD)) regRdData = WORD_W'(cmdWord);
    if (regAddr == ADDR_W'(OFF_ARG)) regRdData = argReg;
    if (regAddr == ADDR_W'(OFF_STS)) regRdData = stsWord;
    for (int k = 0; k < RSP_WORDS; k++) begin
      if (regAddr == ADDR_W'(OFF_RSP0 + 4 * k)) regRdData = rspFlat[k*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/sd_cmd_issue.sv
module sd_cmd_issue
  import sd_cmd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              cardReqValid,
  output logic [5:0]        cardReqIndex,
  output logic [31:0]       cardReqArg,
  input  logic              rspByteValid,
  input  logic [7:0]        rspByte,
  input  logic              rspEnd,
  input  logic [LEN_W-1:0]  rspLen,
  input  logic              rspFail,
  output logic              cmdDone
);
  cmdStrobe_t          stb;
  logic [CMD_W-1:0]    cmdWord;
  logic [WORD_W-1:0]   stsWord;
  logic [RSP_BITS-1:0] rspFlat;

  sd_cmd_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .wrNewBit(regWrData[BIT_NEW]), .cmdNoRsp(cmdWord[BIT_NORSP]),
    .cmdLong(cmdWord[BIT_LONG]), .rspByteValid(rspByteValid),
    .rspEnd(rspEnd), .rspLen(rspLen), .rspFail(rspFail),
    .stb(stb), .busy(cardReqValid), .donePulse(cmdDone)
  );

  sd_cmd_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .regAddr(regAddr),
    .regWrData(regWrData), .rspByte(rspByte), .regRdData(regRdData),
    .cmdWord(cmdWord), .stsWord(stsWord), .rspFlat(rspFlat),
    .reqArg(cardReqArg)
  );

  assign cardReqIndex = cmdWord[IDX_W-1:0];
endmodule

// File: rtl/sd_cmd_issue_chk.sv
module sd_cmd_issue_chk
  import sd_cmd_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                cardReqValid,
  input logic                rspEnd,
  input logic                cmdDone,
  input logic [CMD_W-1:0]    cmdWord,
  input logic [WORD_W-1:0]   stsWord,
  input logic [RSP_BITS-1:0] rspFlat,
  input logic [5:0]          cardReqIndex,
  input logic [31:0]         cardReqArg
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    cardReqValid && !rspEnd |=> cardReqValid); // R3
  AST_PENDING_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    cardReqValid |-> cmdWord[BIT_NEW]); // R3
  AST_END_TO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    cardReqValid && rspEnd |=> cmdDone && !cardReqValid); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |=> !cmdDone); // R4
  AST_DONE_CLEARS_NEW: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |-> !cmdWord[BIT_NEW]); // R4
  AST_FAIL_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone && $rose(cmdWord[BIT_FAIL]) |-> stsWord[STS_TIMEOUT]); // R7
  AST_NORSP_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone && cmdWord[BIT_NORSP] |-> $stable(rspFlat)); // R9
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    cardReqValid && $past(cardReqValid) |-> $stable(cardReqIndex) && $stable(cardReqArg)); // R10
  AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !cardReqValid |=> !cmdDone); // R12
endmodule

bind sd_cmd_issue sd_cmd_issue_chk u_chk (
  .clk(clk), .rstN(rstN), .cardReqValid(cardReqValid), .rspEnd(rspEnd),
  .cmdDone(cmdDone), .cmdWord(cmdWord), .stsWord(stsWord), .rspFlat(rspFlat),
  .cardReqIndex(cardReqIndex), .cardReqArg(cardReqArg)
);

// File: tb/test_sd_cmd_issue.sv
module test_sd_cmd_issue;
  localparam int ADDR_W = 8;
  localparam int LEN_W  = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [31:0]       regWrData = '0;
  logic [31:0]       regRdData;
  logic              cardReqValid;
  logic [5:0]        cardReqIndex;
  logic [31:0]       cardReqArg;
  logic              rspByteValid = 1'b0;
  logic [7:0]        rspByte = '0;
  logic              rspEnd = 1'b0;
  logic [LEN_W-1:0]  rspLen = '0;
  logic              rspFail = 1'b0;
  logic              cmdDone;

  sd_cmd_issue #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_sd_cmd_issue (.*);

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [31:0] expRsp [4];
  logic        expSts;
  logic [7:0]  pay [32];

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  task automatic checkRegs(input string req, input logic [15:0] expCmd);
    logic [31:0] v;
    rd(8'h00, v); check(req, "cmd", v, {16'h0, expCmd});
    rd(8'h20, v); check(req, "status", v, {25'h0, expSts, 6'h0});
    for (int k = 0; k < 4; k++) begin
      rd(8'(8'h10 + 4 * k), v); check(req, $sformatf("rsp%0d", k), v, expRsp[k]);
    end
  endtask

  task automatic launch(input logic [15:0] cmdVal, input logic [31:0] arg, input string req);
    logic [31:0] v;
    wr(8'h04, arg);
    wr(8'h00, {16'h0, cmdVal | 16'h8000});
    check(req, "reqValid", {31'h0, cardReqValid}, 32'h1);
    check(req, "reqIndex", {26'h0, cardReqIndex}, {26'h0, cmdVal[5:0]});
    check(req, "reqArg", cardReqArg, arg);
    rd(8'h00, v); check(req, "pending cmd", v, {16'h0, cmdVal | 16'h8000});
  endtask

  task automatic feed(input int n);
    for (int i = 0; i < n; i++) begin
      rspByteValid = 1'b1; rspByte = pay[i];
      @(posedge clk); @(negedge clk);
    end
    rspByteValid = 1'b0;
  endtask

  task automatic finish(input logic [15:0] cmdVal, input logic [LEN_W-1:0] len, input logic fail, input string req);
    logic failExp;
    rspEnd = 1'b1; rspLen = len; rspFail = fail;
    @(posedge clk); @(negedge clk);
    rspEnd = 1'b0; rspFail = 1'b0;
    check("R4", "done", {31'h0, cmdDone}, 32'h1);
    check("R4", "reqValid low", {31'h0, cardReqValid}, 32'h0);
    failExp = fail;
    if (!fail && !cmdVal[10]) begin
      if (len == 4 && !cmdVal[9]) begin
        expRsp[0] = {pay[0], pay[1], pay[2], pay[3]};
        for (int k = 1; k < 4; k++) expRsp[k] = '0;
      end else if (len == 16) begin
        for (int k = 0; k < 4; k++)
          expRsp[k] = {pay[12-4*k], pay[13-4*k], pay[14-4*k], pay[15-4*k]};
      end else begin
        failExp = 1'b1;
      end
    end
    if (failExp) expSts = 1'b1;
    checkRegs(req, (cmdVal & 16'h7FFF) | (failExp ? 16'h4000 : 16'h0));
    @(posedge clk); @(negedge clk);
    check("R4", "done one cycle", {31'h0, cmdDone}, 32'h0);
  endtask

  task automatic issue(input logic [15:0] cmdVal, input logic [31:0] arg, input logic [LEN_W-1:0] len, input logic fail, input string req);
    launch(cmdVal, arg, "R3");
    feed(int'(len));
    finish(cmdVal, len, fail, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int k = 0; k < 4; k++) expRsp[k] = '0;
    expSts = 1'b0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "reqValid", {31'h0, cardReqValid}, 32'h0);
    check("R1", "done", {31'h0, cmdDone}, 32'h0);
    rd(8'h04, v); check("R1", "arg", v, 32'h0);
    checkRegs("R1", 16'h0);

    // R2 plain stores
    wr(8'h04, 32'hDEADBEEF);
    rd(8'h04, v); check("R2", "arg readback", v, 32'hDEADBEEF);
    wr(8'h00, 32'h0000_0245);
    rd(8'h00, v); check("R2", "cmd stored", v, 32'h0245);
    @(negedge clk);
    check("R2", "no request", {31'h0, cardReqValid}, 32'h0);

    // R5 short response
    pay[0] = 8'h11; pay[1] = 8'h22; pay[2] = 8'h33; pay[3] = 8'h44;
    issue(16'h0011, 32'h1234_5678, 5'd4, 1'b0, "R5");

    // R6 long response
    for (int i = 0; i < 16; i++) pay[i] = 8'(8'hA0 + i);
    issue(16'h0202, 32'h0, 5'd16, 1'b0, "R6");

    // R7 bad lengths
    issue(16'h0003, 32'h1, 5'd0, 1'b0, "R7");
    wr(8'h20, 32'h40); expSts = 1'b0;
    issue(16'h0204, 32'h2, 5'd4, 1'b0, "R7");
    issue(16'h0005, 32'h3, 5'd7, 1'b0, "R7");

    // R11 status clear rules
    wr(8'h20, 32'hFFFF_FFBF);
    rd(8'h20, v); check("R11", "zero write keeps", v, 32'h40);
    wr(8'h20, 32'h40); expSts = 1'b0;
    rd(8'h20, v); check("R11", "w1c", v, 32'h0);

    // R8 card failure with valid length
    issue(16'h0006, 32'h4, 5'd4, 1'b1, "R8");
    wr(8'h20, 32'h40); expSts = 1'b0;

    // R9 no response with odd length
    issue(16'h0407, 32'h5, 5'd3, 1'b0, "R9");

    // R10 writes during a pending request
    launch(16'h0009, 32'hCAFE_0001, "R3");
    wr(8'h00, 32'h0000_8005);
    wr(8'h04, 32'h5555_AAAA);
    check("R10", "index kept", {26'h0, cardReqIndex}, 32'h9);
    check("R10", "arg kept", cardReqArg, 32'hCAFE_0001);
    rd(8'h00, v); check("R10", "cmd kept", v, 32'h8009);
    rd(8'h04, v); check("R10", "arg reg updated", v, 32'h5555_AAAA);
    pay[0] = 8'h01; pay[1] = 8'h02; pay[2] = 8'h03; pay[3] = 8'h04;
    feed(4);
    finish(16'h0009, 5'd4, 1'b0, "R10");

    // R12 traffic while idle
    pay[0] = 8'hEE; pay[1] = 8'hDD; pay[2] = 8'hCC; pay[3] = 8'hBB;
    feed(4);
    rspEnd = 1'b1; rspLen = 5'd4;
    @(posedge clk); @(negedge clk);
    rspEnd = 1'b0;
    check("R12", "no done", {31'h0, cmdDone}, 32'h0);
    check("R12", "no request", {31'h0, cardReqValid}, 32'h0);
    checkRegs("R12", 16'h0009);

    // randomized mix
    for (int it = 0; it < 60; it++) begin
      logic [15:0] c;
      logic [LEN_W-1:0] len;
      logic f;
      c = 16'($urandom) & 16'h7FFF;
      c[10] = ($urandom % 4 == 0);
      c[9]  = $urandom % 2;
      case ($urandom % 4)
        0: len = 5'd4;
        1: len = 5'd16;
        2: len = 5'd0;
        default: len = 5'($urandom % 32);
      endcase
      f = ($urandom % 8 == 0);
      for (int i = 0; i < 32; i++) pay[i] = 8'($urandom);
      if ($urandom % 3 == 0) begin
        wr(8'h20, 32'h40); expSts = 1'b0;
      end
      issue(c, $urandom, len, f, "R7 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule